// File: doc/BRIEF.md
# Direct-Mapped Instruction Fetch Cache

This block sits between a processor's instruction-fetch port and main memory. It holds 4096 bytes of opcodes as 256 lines of 16 bytes, one location per line. A fetch whose address lies in one of the two cacheable RAM segments is looked up by index. On a hit the stored opcode is returned and memory is not touched. On a miss the whole aligned line is read from memory, one word at a time, and then the requested word is returned. A fetch outside those segments bypasses the arrays: it makes a single memory read and stores nothing.

The segment is the top address byte. Only the 24-bit offset inside a segment is kept as the tag, so the two cacheable segments reach the same lines. Code stores never reach the cache, so a hit can return an opcode that memory has since replaced. A one-cycle `flush` pulse, raised when the processor isolates its cache, clears every line at once. If a line fill is running it is dropped and started again from its first word.

The controller has four states. IDLE accepts a fetch. LOOKUP compares the tag. FILL reads the four words of a line. BYPASS makes one uncached read. The transitions are:
- ACCEPT_CACHED: IDLE to LOOKUP.
- ACCEPT_UNCACHED: IDLE to BYPASS.
- HIT_DONE: LOOKUP to IDLE, with a response.
- MISS_START: LOOKUP to FILL.
- FLUSH_RETRY: LOOKUP to LOOKUP, or FILL to LOOKUP.
- LINE_DONE: FILL to LOOKUP after the fourth word.
- BYPASS_DONE: BYPASS to IDLE, with a response.

Top module: `ifetch_cache`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` and `mem_req` are 0. Every line is invalid, including one whose address offset is all ones (0xFFFFFC), so the first fetch to any line misses.
- R2: A fetch is cacheable when its address bits [31:24] are 0x00 or 0x80. A cacheable miss issues exactly four memory reads at line base + 0, 4, 8 and 12, in that order. The response then carries the word at the fetch address.
- R3: Any other top byte causes exactly one memory read, at the fetch address. Its data is returned and nothing is stored, so repeating the fetch reads memory again.
- R4: A hit makes no memory read. `rsp_valid` is high in the cycle after the first rising edge that follows the acceptance edge.
- R5: The tag is address bits [23:12]. Fetches in segments 0x00 and 0x80 with equal offsets share a line. Two offsets with the same bits [11:4] but different bits [23:12] evict each other.
- R6: One cycle of `flush` invalidates every line, so the next fetch to any previously filled line misses.
- R7: A `flush` during a line fill drops `mem_req` in the next cycle. The fill then restarts from offset 0 and the fetch still returns correct data.
- R8: A hit returns the opcode captured at fill time, even after the memory contents at that address change.
- R9: Only one fetch is outstanding. `req_ready` is 0 from the cycle after acceptance until the response, and `rsp_valid` is a single-cycle pulse.
- R10: While `mem_req` waits for `mem_ack` without a flush, `mem_req` stays high and `mem_addr` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | One-cycle pulse that invalidates all lines |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Block can accept a fetch (IDLE) |
| req_addr | input | 32 | Fetch byte address |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Returned opcode |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 32 | Memory read address |
| mem_ack | input | 1 | Memory read complete, data valid |
| mem_rdata | input | 32 | Memory read data |

## Verification
Memory contents are a hash of the in-segment word address mixed with a version word, so every returned opcode can be recomputed.

A cold sweep touches all 256 lines at varying memory latency, which separates correct beat ordering from a misplaced word. A hit sweep over all 1024 words through the other segment tells aliasing and hit latency apart from a refetch. Changing the version word then separates a stale hit from a silent refill. A sweep over all 256 top-byte values tells cacheable segments from bypass. Conflict, flush-while-idle and flush-mid-fill sequences expose wrong tag width, leftover valid bits and an unrestarted fill.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FILL,
        ST_BYPASS
    } ifc_state_e;
endpackage

// File: rtl/ifc_tag_store.sv
module ifc_tag_store #(
    parameter int LINES = 256,
    parameter int TAG_W = 12,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag
);
    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Flush wins over a same-cycle install.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < LINES; i++) tag_q[i] <= '1;
        end else if (flush) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            tag_q[wr_idx]   <= wr_tag;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

    assert_flush_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));
endmodule

// File: rtl/ifc_data_store.sv
module ifc_data_store #(
    parameter int WORDS  = 1024,
    parameter int WORD_W = 32,
    localparam int AW = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/ifetch_cache.sv
module ifetch_cache
    import ifc_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter int          WORD_W      = 32,
    parameter int          CACHE_BYTES = 4096,
    parameter int          LINE_BYTES  = 16,
    parameter int          OFFSET_W    = 24,
    parameter logic [7:0]  SEG_LOW     = 8'h00,
    parameter logic [7:0]  SEG_HIGH    = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int BYTE_OFF   = $clog2(WORD_BYTES);
    localparam int LINE_OFF   = $clog2(LINE_BYTES);
    localparam int INDEX_TOP  = $clog2(CACHE_BYTES);
    localparam int LINES      = CACHE_BYTES / LINE_BYTES;
    localparam int WORDS      = CACHE_BYTES / WORD_BYTES;
    localparam int BEATS      = LINE_BYTES / WORD_BYTES;
    localparam int BEAT_W     = $clog2(BEATS);
    localparam int IDX_W      = $clog2(LINES);
    localparam int WADDR_W    = $clog2(WORDS);
    localparam int TAG_W      = OFFSET_W - INDEX_TOP;
    localparam int SEG_W      = ADDR_W - OFFSET_W;

    ifc_state_e          state_q, state_d;
    logic [ADDR_W-1:0]   addr_q;
    logic [BEAT_W-1:0]   beat_q;
    logic                rsp_valid_q;
    logic [WORD_W-1:0]   rsp_data_q;

    logic                tag_valid;
    logic [TAG_W-1:0]    tag_rd;
    logic [WORD_W-1:0]   word_rd;
    logic                hit, last_beat, req_cacheable;
    logic                data_we, tag_we;
    logic [IDX_W-1:0]    line_idx;
    logic [WADDR_W-1:0]  wr_word;

    assign req_cacheable = (req_addr[ADDR_W-1 -: SEG_W] == SEG_LOW) ||
                           (req_addr[ADDR_W-1 -: SEG_W] == SEG_HIGH);
    assign line_idx  = addr_q[INDEX_TOP-1:LINE_OFF];
    assign hit       = tag_valid && (tag_rd == addr_q[OFFSET_W-1:INDEX_TOP]);
    assign last_beat = (beat_q == BEAT_W'(BEATS - 1));
    assign wr_word   = {line_idx, beat_q};

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = req_cacheable ? ST_LOOKUP : ST_BYPASS;
            ST_LOOKUP: if (flush)     state_d = ST_LOOKUP;
                       else if (hit)  state_d = ST_IDLE;
                       else           state_d = ST_FILL;
            ST_FILL:   if (flush)     state_d = ST_LOOKUP;
                       else if (mem_ack && last_beat) state_d = ST_LOOKUP;
            ST_BYPASS: if (mem_ack)   state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // State and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            addr_q      <= '0;
            beat_q      <= '0;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            state_q     <= state_d;
            rsp_valid_q <= 1'b0;
            if (state_q == ST_IDLE && req_valid) addr_q <= req_addr;
            if (state_q != ST_FILL)              beat_q <= '0;
            else if (mem_ack && !flush)          beat_q <= beat_q + 1'b1;
            if (state_q == ST_LOOKUP && !flush && hit) begin
                rsp_valid_q <= 1'b1;
                rsp_data_q  <= word_rd;
            end
            if (state_q == ST_BYPASS && mem_ack) begin
                rsp_valid_q <= 1'b1;
                rsp_data_q  <= mem_rdata;
            end
        end
    end

    // Outputs and array controls
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        mem_req   = (state_q == ST_FILL) || (state_q == ST_BYPASS);
        mem_addr  = (state_q == ST_FILL)
                  ? {addr_q[ADDR_W-1:LINE_OFF], beat_q, {BYTE_OFF{1'b0}}}
                  : addr_q;
        data_we   = (state_q == ST_FILL) && mem_ack && !flush;
        tag_we    = data_we && last_beat;
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;

    ifc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .wr_en    (tag_we),
        .wr_idx   (line_idx),
        .wr_tag   (addr_q[OFFSET_W-1:INDEX_TOP]),
        .rd_idx   (line_idx),
        .rd_valid (tag_valid),
        .rd_tag   (tag_rd)
    );

    ifc_data_store #(.WORDS(WORDS), .WORD_W(WORD_W)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (data_we),
        .wr_addr (wr_word),
        .wr_data (mem_rdata),
        .rd_addr (addr_q[INDEX_TOP-1:BYTE_OFF]),
        .rd_data (word_rd)
    );

    assert_bypass_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_cacheable) |=>
            (mem_req && mem_addr == $past(req_addr)));
    assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !flush) |=> (mem_req && $stable(mem_addr)));
    assert_fill_abandon_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && state_q == ST_FILL) |=> !mem_req);
    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/ifetch_cache_tb.sv
module ifetch_cache_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    int cfg_lat = 0;
    int wait_cnt = 0;
    int log_n = 0;
    logic [31:0] log_q [16];
    logic [31:0] ack_addr = '0;
    logic [31:0] mem_xor = '0;

    always #5 clk = ~clk;

    ifetch_cache u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] mem_f(logic [31:0] a, logic [31:0] x);
        return ({8'h00, a[23:2], 2'b00} * 32'h9E3779B1) ^ x;
    endfunction

    // Memory model: acts 2 ns after each rising edge.
    always @(posedge clk) begin
        #2;
        if (mem_ack) begin
            log_q[log_n % 16] = ack_addr;
            log_n++;
            mem_ack  = 1'b0;
            wait_cnt = 0;
        end else if (mem_req) begin
            if (wait_cnt >= cfg_lat) begin
                mem_ack   = 1'b1;
                mem_rdata = mem_f(mem_addr, mem_xor);
                ack_addr  = mem_addr;
            end else begin
                wait_cnt++;
            end
        end else begin
            wait_cnt = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_fetch(input logic [31:0] a, output logic [31:0] d,
                            output int nreads, output int cyc);
        int start;
        bit busy_bad;
        busy_bad = 1'b0;
        @(negedge clk);
        chk(req_ready, "R9 ready before fetch", 32'(req_ready), 32'd1);
        start = log_n;
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!rsp_valid && cyc < 1000) begin
            if (req_ready) busy_bad = 1'b1;
            @(negedge clk);
            cyc++;
        end
        d = rsp_data;
        nreads = log_n - start;
        chk(!busy_bad, "R9 ready low while busy", 32'(busy_bad), 32'd0);
        @(negedge clk);
        chk(!rsp_valid, "R9 response is one pulse", 32'(rsp_valid), 32'd0);
    endtask

    task automatic pulse_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic check_line_order(input logic [31:0] a, input string tag);
        for (int k = 0; k < 4; k++) begin
            logic [31:0] got;
            logic [31:0] exp;
            got = log_q[(log_n - 4 + k) % 16];
            exp = {a[31:4], 4'h0} + 32'(4 * k);
            chk(got == exp, tag, got, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL R9 watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d, a;
        int nr, cyc;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R1 reset req_ready", 32'(req_ready), 32'd1);
        chk(!rsp_valid, "R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk(!mem_req, "R1 reset mem_req", 32'(mem_req), 32'd0);

        // R1: the all-ones offset must not hit after reset
        do_fetch(32'h00FF_FFFC, d, nr, cyc);
        chk(nr == 4, "R1 all-ones offset misses", 32'(nr), 32'd4);
        chk(d == mem_f(32'h00FF_FFFC, mem_xor), "R1 all-ones data", d, mem_f(32'h00FF_FFFC, mem_xor));

        // R2: cold fill of every line, varying latency and word within the line
        for (int i = 0; i < 256; i++) begin
            cfg_lat = i % 3;
            a = 32'(i * 16 + (i % 4) * 4);
            do_fetch(a, d, nr, cyc);
            chk(nr == 4, "R2 miss read count", 32'(nr), 32'd4);
            chk(d == mem_f(a, mem_xor), "R2 miss data", d, mem_f(a, mem_xor));
            check_line_order(a, "R2 fill order");
        end

        // R4 and R5: every word through the aliased segment hits
        cfg_lat = 1;
        for (int w = 0; w < 1024; w++) begin
            a = 32'h8000_0000 + 32'(w * 4);
            do_fetch(a, d, nr, cyc);
            chk(nr == 0, "R4 hit makes no read", 32'(nr), 32'd0);
            chk(cyc == 2, "R4 hit latency", 32'(cyc), 32'd2);
            chk(d == mem_f(a, 32'h0), "R5 alias hit data", d, mem_f(a, 32'h0));
        end

        // R8: memory changes, but hits keep the opcodes captured at fill time
        mem_xor = 32'hFFFF_0000;
        for (int w = 0; w < 1024; w += 37) begin
            a = 32'(w * 4);
            do_fetch(a, d, nr, cyc);
            chk(nr == 0, "R8 stale hit no read", 32'(nr), 32'd0);
            chk(d == mem_f(a, 32'h0), "R8 stale opcode", d, mem_f(a, 32'h0));
        end

        // R3 and R2: sweep all segment bytes after a flush
        pulse_flush();
        for (int b = 0; b < 256; b++) begin
            int expn;
            a = {8'(b), 24'h000124};
            expn = (b == 0) ? 4 : ((b == 8'h80) ? 0 : 1);
            do_fetch(a, d, nr, cyc);
            chk(nr == expn, "R3 reads per segment byte", 32'(nr), 32'(expn));
            chk(d == mem_f(a, mem_xor), "R3 segment data", d, mem_f(a, mem_xor));
            if (expn == 1) chk(log_q[(log_n - 1) % 16] == a, "R3 bypass address", log_q[(log_n - 1) % 16], a);
        end
        for (int r = 0; r < 2; r++) begin
            do_fetch(32'h1F00_0124, d, nr, cyc);
            chk(nr == 1, "R3 bypass not stored", 32'(nr), 32'd1);
        end

        // R6: flush invalidates a filled line
        do_fetch(32'h0000_0124, d, nr, cyc);
        chk(nr == 0, "R6 line cached before flush", 32'(nr), 32'd0);
        pulse_flush();
        do_fetch(32'h0000_0124, d, nr, cyc);
        chk(nr == 4, "R6 miss after flush", 32'(nr), 32'd4);

        // R5: same index, different tag bits [23:12]
        do_fetch(32'h0000_1128, d, nr, cyc);
        chk(nr == 4, "R5 conflict miss", 32'(nr), 32'd4);
        chk(d == mem_f(32'h0000_1128, mem_xor), "R5 conflict data", d, mem_f(32'h0000_1128, mem_xor));
        do_fetch(32'h00FF_F120, d, nr, cyc);
        chk(nr == 4, "R5 top tag bit differs", 32'(nr), 32'd4);
        do_fetch(32'h0000_0124, d, nr, cyc);
        chk(nr == 4, "R5 evicted line refills", 32'(nr), 32'd4);
        do_fetch(32'h0000_0124, d, nr, cyc);
        chk(nr == 0, "R5 refilled line hits", 32'(nr), 32'd0);

        // R7: flush in the middle of a fill
        cfg_lat = 2;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 32'h0000_0238;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
        chk(mem_req, "R7 fill under way", 32'(mem_req), 32'd1);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk(!mem_req, "R7 request dropped on flush", 32'(mem_req), 32'd0);
        cyc = 0;
        while (!rsp_valid && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
        chk(rsp_data == mem_f(32'h0000_0238, mem_xor), "R7 data after restart",
            rsp_data, mem_f(32'h0000_0238, mem_xor));
        check_line_order(32'h0000_0238, "R7 restart order");
        @(negedge clk);
        chk(!rsp_valid, "R9 single pulse after restart", 32'(rsp_valid), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule